// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is the command logic of a small serial EEPROM sitting on a three-wire bus with a separate select line. A host raises the select, clocks in a start bit, a two-bit opcode, an address and, for a write, a data word. The block then reads, programs, erases or changes its write-protection state. The memory array is a register file. Erase leaves a word all ones, and the array comes out of reset in that erased state. Select, clock and data-in are sampled in the system clock domain through two-flop synchronisers. Serial clock edges are recovered from the synchronised level.

Programming and erasing run as a self-timed cycle. The cycle lasts a parameterised number of system clocks and starts only when the select falls at the right moment. While it runs, the host can raise the select and poll the data output: the block holds it low while busy and drives it high once ready. Reads return a leading zero and then the addressed word. If the select stays high, the block walks on through the array with no further leading zeros.

Top module: `sermem_slave`

## Requirements
- R1: After reset the data output is 0 while select is low, programming commands are locked out, and every word of the array reads as all ones.
- R2: After select rises, data-in samples of 0 on rising serial clock edges are skipped. The first 1 sampled is the start bit, and the next two samples form the opcode, first sample in the upper bit.
- R3: Opcode 10 is a read. During the high phase of the clock edge that samples the last address bit, the output is 0. Each following rising edge then presents the next bit of the addressed word, most significant bit first.
- R4: While select stays high after a read word, the address increments by one and the next word follows at once, with no leading 0. The address wraps from the last word to word 0.
- R5: Opcode 00 with the two upper address bits at 11 unlocks programming, and with them at 00 locks it again. While locked, write, erase and erase-all leave the array unchanged. Reads work in both states.
- R6: Opcode 01 takes an address and then a data word, most significant bit first. If select then falls before the next rising serial edge and programming is unlocked, the whole word is replaced by the data once the self-timed cycle ends.
- R7: If a rising serial edge arrives after the last data bit of a write and before select falls, nothing is programmed.
- R8: Opcode 11 sets the addressed word to all ones, starting when select falls after the address has been received.
- R9: Opcode 00 with the two upper address bits at 10 sets every word to all ones when select falls.
- R10: While the self-timed cycle runs, the output is 0 whenever select is high, and any command clocked in is ignored. Once the cycle has ended, the output is 1 while select is high. A new command needs a fresh rising edge on select.
- R11: If select falls before a command is complete, the command is abandoned with no effect, and the next command on a fresh select is decoded normally.
- R12: Outside a read and outside a self-timed cycle, the output follows the select level: 1 while select is high, 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Select from the bus host, active high |
| sck_i | input | 1 | Serial clock; data is sampled and shifted on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data, busy (0) or ready (1) |

## Verification
The bench builds the block with 8-bit words, a 4-bit address and a 300-clock program cycle. With only sixteen words, it can program every address with a distinct computed pattern and read the whole array back in one sequential burst, which forces the address to wrap. A cycle of 300 clocks is longer than a complete write command on the serial bus, so a full command can be clocked in during the busy phase to show it has no effect. The bench also covers a late select after a write, a command abandoned partway, and each locked and unlocked programming command.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_OPC, ST_ADDR, ST_DATA, ST_WIN, ST_HOLD, ST_READ, ST_PROG
  } st_e;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {PG_NONE, PG_WORD, PG_ALL} pg_e;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_ERAALL = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
  assign fall_o = ~sr_q[STAGES-1] & sr_q[STAGES];
endmodule

// File: rtl/sermem_timer.sv
module sermem_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '1;
      else if (clr_i)                                   mem_q[g] <= '1;
      else if (wr_i && (waddr_i == ADDR_W'(g)))         mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
  import sermem_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  output logic do_o
);
  localparam int MAXW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNW  = $clog2(MAXW + 1);

  // synchronised bus: index 0 select, 1 clock, 2 data
  logic [2:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {di_i, sck_i, cs_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    sermem_sync #(.STAGES(2)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[g]),
      .lvl_o (pin_lvl[g]),
      .rise_o(pin_rise[g]),
      .fall_o(pin_fall[g])
    );
  end

  logic cs_lvl, cs_rise, cs_fall, sck_rise, di_lvl;
  assign cs_lvl   = pin_lvl[0];
  assign cs_rise  = pin_rise[0];
  assign cs_fall  = pin_fall[0];
  assign sck_rise = pin_rise[1];
  assign di_lvl   = pin_lvl[2];

  st_e               st_q, st_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic [CNW-1:0]    cnt_q, cnt_d;
  pg_e               pg_q, pg_d;
  logic              we_en, we_en_d;
  logic              out_q, out_d;

  logic              tmr_start, busy, tmr_done;
  logic              mem_wr, mem_clr;
  logic [ADDR_W-1:0] addr_in, rd_addr;
  logic [DATA_W-1:0] rdata;

  assign addr_in = {sh_q[ADDR_W-2:0], di_lvl};
  assign rd_addr = (st_q == ST_READ) ? sh_q + 1'b1 : addr_in;

  sermem_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .busy_o (busy),
    .done_o (tmr_done)
  );

  assign mem_wr  = (st_q == ST_PROG) && tmr_done && (pg_q == PG_WORD);
  assign mem_clr = (st_q == ST_PROG) && tmr_done && (pg_q == PG_ALL);

  sermem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mem_wr),
    .clr_i  (mem_clr),
    .waddr_i(sh_q),
    .wdata_i(dat_q),
    .raddr_i(rd_addr),
    .rdata_o(rdata)
  );

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    sh_d      = sh_q;
    dat_d     = dat_q;
    rsh_d     = rsh_q;
    cnt_d     = cnt_q;
    pg_d      = pg_q;
    we_en_d   = we_en;
    out_d     = out_q;
    tmr_start = 1'b0;

    unique case (st_q)
      ST_IDLE: if (cs_rise) st_d = ST_START;

      ST_START: begin
        if (!cs_lvl) st_d = ST_IDLE;
        else if (sck_rise && di_lvl) begin
          st_d  = ST_OPC;
          cnt_d = '0;
        end
      end

      ST_OPC: begin
        if (!cs_lvl) st_d = ST_IDLE;
        else if (sck_rise) begin
          op_d  = {op_q[0], di_lvl};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNW'(1)) begin
            st_d  = ST_ADDR;
            cnt_d = '0;
          end
        end
      end

      ST_ADDR: begin
        if (!cs_lvl) st_d = ST_IDLE;
        else if (sck_rise) begin
          sh_d  = addr_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNW'(ADDR_W - 1)) begin
            cnt_d = '0;
            pg_d  = PG_NONE;
            st_d  = ST_HOLD;
            unique case (op_e'(op_q))
              OP_READ: begin
                st_d  = ST_READ;
                rsh_d = rdata;
                out_d = 1'b0;
              end
              OP_WRITE: st_d = ST_DATA;
              OP_ERASE: begin
                pg_d  = PG_WORD;
                dat_d = '1;
              end
              OP_EXT: begin
                unique case (addr_in[ADDR_W-1 -: 2])
                  EXT_UNLOCK: we_en_d = 1'b1;
                  EXT_LOCK:   we_en_d = 1'b0;
                  EXT_ERAALL: pg_d    = PG_ALL;
                  default:    pg_d    = PG_NONE;
                endcase
              end
            endcase
          end
        end
      end

      ST_DATA: begin
        if (!cs_lvl) st_d = ST_IDLE;
        else if (sck_rise) begin
          dat_d = {dat_q[DATA_W-2:0], di_lvl};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNW'(DATA_W - 1)) begin
            st_d = ST_WIN;
            pg_d = PG_WORD;
          end
        end
      end

      // write: select must drop before another serial clock edge
      ST_WIN, ST_HOLD: begin
        if (st_q == ST_WIN && sck_rise) begin
          st_d = ST_HOLD;
          pg_d = PG_NONE;
        end else if (!cs_lvl) begin
          if (we_en && pg_q != PG_NONE) begin
            tmr_start = 1'b1;
            st_d      = ST_PROG;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end

      ST_READ: begin
        if (!cs_lvl) st_d = ST_IDLE;
        else if (sck_rise) begin
          if (cnt_q == CNW'(DATA_W)) begin
            sh_d  = sh_q + 1'b1;
            out_d = rdata[DATA_W-1];
            rsh_d = {rdata[DATA_W-2:0], 1'b0};
            cnt_d = CNW'(1);
          end else begin
            out_d = rsh_q[DATA_W-1];
            rsh_d = {rsh_q[DATA_W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      ST_PROG: if (tmr_done) st_d = ST_IDLE;

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      rsh_q <= '0;
      cnt_q <= '0;
      pg_q  <= PG_NONE;
      we_en <= 1'b0;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      op_q  <= op_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      rsh_q <= rsh_d;
      cnt_q <= cnt_d;
      pg_q  <= pg_d;
      we_en <= we_en_d;
      out_q <= out_d;
    end
  end

  assign do_o = (st_q == ST_READ) ? out_q : (cs_lvl && st_q != ST_PROG);
endmodule

// File: rtl/sermem_slave_chk.sv
module sermem_slave_chk
  import sermem_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_lvl_i,
  input logic busy_i,
  input logic we_en_i,
  input logic mem_wr_i,
  input logic mem_clr_i,
  input st_e  st_i,
  input logic do_i
);
  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cs_lvl_i) |-> !do_i);  // R10

  AST_NO_PROG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> we_en_i);  // R5

  AST_START_ON_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!cs_lvl_i));  // R7

  AST_SINGLE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_wr_i, mem_clr_i}));  // R9

  AST_UPDATE_ENDS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i || mem_clr_i) |=> !busy_i);  // R6

  AST_READ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_READ) |-> !busy_i);  // R3
endmodule

bind sermem_slave sermem_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_lvl_i (cs_lvl),
  .busy_i   (busy),
  .we_en_i  (we_en),
  .mem_wr_i (mem_wr),
  .mem_clr_i(mem_clr),
  .st_i     (st_q),
  .do_i     (do_o)
);

// File: tb/sermem_slave_bench.sv
module sermem_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int AW   = 4;
  localparam int PROG = 300;
  localparam int HP   = 6;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic dout;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [DW-1:0] model [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  sermem_slave #(.DATA_W(DW), .ADDR_W(AW), .PROG_CYCLES(PROG)) u_sermem_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di), .do_o(dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic q);
    di = b;
    wait_clk(HP);
    sck = 1'b1;
    wait_clk(HP);
    q = dout;
    sck = 1'b0;
  endtask

  task automatic sel();
    wait_clk(1);
    cs = 1'b1;
    wait_clk(HP);
  endtask

  task automatic desel();
    wait_clk(HP);
    cs = 1'b0;
    wait_clk(HP);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [AW-1:0] a, output logic q);
    bitx(1'b1, q);
    bitx(op[1], q);
    bitx(op[0], q);
    for (int i = AW - 1; i >= 0; i--) bitx(a[i], q);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    logic q;
    for (int i = DW - 1; i >= 0; i--) bitx(d[i], q);
  endtask

  task automatic get_word(output logic [DW-1:0] w);
    logic q;
    for (int i = DW - 1; i >= 0; i--) begin
      bitx(1'b0, q);
      w[i] = q;
    end
  endtask

  task automatic wait_prog();
    wait_clk(PROG + 20);
  endtask

  // read n words starting at a, dummy then data, wrapping
  task automatic read_seq(input logic [AW-1:0] a, input int n, input string req);
    logic q;
    logic [DW-1:0] w;
    sel();
    hdr(2'b10, a, q);
    chk(q == 1'b0, "R3 dummy bit", int'(q), 0);
    for (int k = 0; k < n; k++) begin
      get_word(w);
      chk(w == model[(int'(a) + k) % NW], req, int'(w), int'(model[(int'(a) + k) % NW]));
    end
    desel();
  endtask

  task automatic ext_cmd(input logic [1:0] code);
    logic q;
    sel();
    hdr(2'b00, {code, {(AW-2){1'b0}}}, q);
    desel();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit late);
    logic q;
    sel();
    hdr(2'b01, a, q);
    send_data(d);
    if (late) bitx(1'b0, q);
    desel();
    wait_prog();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 29 + 7) ^ (a << 4));
  endfunction

  initial begin
    logic q;
    logic [DW-1:0] w;
    for (int i = 0; i < NW; i++) model[i] = '1;
    wait_clk(4);
    chk(dout == 1'b0, "R1 reset output", int'(dout), 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk(dout == 1'b0, "R1 output after reset", int'(dout), 0);

    // R1 erased array, R3/R4 one full sequential burst
    read_seq('0, NW, "R1 erased word");

    // R5 locked write is dropped
    write_word(4'd3, 8'h5A, 1'b0);
    read_seq(4'd3, 1, "R5 locked write");

    // R5 unlock; R6 program every word
    ext_cmd(2'b11);
    for (int a = 0; a < NW; a++) begin
      write_word(AW'(a), pat(a), 1'b0);
      model[a] = pat(a);
    end
    read_seq(4'd5, NW + 1, "R4 wrap burst / R6 programmed");

    // R2 leading zeros before start bit
    sel();
    bitx(1'b0, q);
    bitx(1'b0, q);
    bitx(1'b0, q);
    hdr(2'b10, 4'd9, q);
    chk(q == 1'b0, "R2 dummy after zeros", int'(q), 0);
    get_word(w);
    chk(w == model[9], "R2 word after zeros", int'(w), int'(model[9]));
    desel();

    // R7 late deselect after write
    write_word(4'd2, 8'h00, 1'b1);
    read_seq(4'd2, 1, "R7 late deselect");

    // R10 busy polling with an ignored command
    sel();
    hdr(2'b01, 4'd4, q);
    send_data(8'hC3);
    desel();
    model[4] = 8'hC3;
    wait_clk(2);
    cs = 1'b1;
    wait_clk(HP);
    chk(dout == 1'b0, "R10 busy", int'(dout), 0);
    hdr(2'b01, 4'd6, q);
    send_data(8'h11);
    chk(dout == 1'b0, "R10 busy during command", int'(dout), 0);
    desel();
    cs = 1'b1;
    wait_clk(PROG);
    chk(dout == 1'b1, "R10 ready", int'(dout), 1);
    desel();
    read_seq(4'd4, 3, "R10 ignored command / R6");

    // R8 erase word
    sel();
    hdr(2'b11, 4'd7, q);
    desel();
    wait_prog();
    model[7] = '1;
    read_seq(4'd6, 3, "R8 erase word");

    // R11 aborted write
    sel();
    hdr(2'b01, 4'd8, q);
    bitx(1'b0, q);
    bitx(1'b0, q);
    bitx(1'b0, q);
    desel();
    wait_prog();
    read_seq(4'd8, 1, "R11 abort leaves word");

    // R12 output follows select when idle
    sel();
    chk(dout == 1'b1, "R12 select high", int'(dout), 1);
    desel();
    chk(dout == 1'b0, "R12 select low", int'(dout), 0);

    // R5 lock again: write and erase-all dropped
    ext_cmd(2'b00);
    write_word(4'd1, 8'h3C, 1'b0);
    ext_cmd(2'b10);
    wait_prog();
    read_seq(4'd0, NW, "R5 locked commands");

    // R9 erase-all
    ext_cmd(2'b11);
    ext_cmd(2'b10);
    wait_prog();
    for (int i = 0; i < NW; i++) model[i] = '1;
    read_seq(4'd11, NW, "R9 erase all");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule